// File: doc/BRIEF.md
# Multiply / Multiply-Accumulate Coprocessor

This block is an unsigned 32x32 to 64-bit multiplier that sits beside a CPU register file and talks to it through a narrow byte-lane transfer port. Its operands always come from two dedicated CPU registers, presented to the block as `op_a_i` and `op_b_i` on every cycle. Software sees the block as a three-word window occupying CPU register indices 25, 26 and 27. Index 25 is a control word. Indices 26 and 27 are the low and high halves of the 64-bit product.

There are two modes. In multiply-only mode the block multiplies on every clock and holds its hidden 64-bit accumulator at zero. In accumulate mode nothing happens on its own. Each write transfer that starts at index 25 samples the operands once, adds their product into the accumulator and publishes the sum in the product words. A carry flag records a 64-bit wrap. Writing 1 to that flag clears it and empties the accumulator.

Transfers move any run of bytes, from a start register and byte lane, through a length. The lane wraps after 3 and the register index then advances. A transfer that leaves the window is flagged as an error and has no effect.

Top module: `mac_coproc`

## Requirements
- R1: While reset is asserted and right after it, the window reads all zero: multiply-only mode, carry clear, product zero.
- R2: In multiply-only mode, the product words on `xfr_rdata_o[95:32]` equal the unsigned product of `op_a_i` and `op_b_i` as sampled at the previous rising clock edge. Slot 26 is bits 63:32 and holds the low half. Slot 27 is bits 95:64 and holds the high half.
- R3: A transfer is legal only if its start register is at least 25 and register*4 + lane + length is at most 112. `xfr_err_o` is high in the same cycle for any valid illegal transfer, and an illegal write changes no state.
- R4: For a legal valid transfer, `xfr_mask_o` bit k is set exactly for the window bytes k = (reg-25)*4 + lane + i, with i from 0 to length-1. The mask is zero otherwise. Byte k is `xfr_rdata_o[8k+7:8k]`.
- R5: A legal write (`xfr_dir_i`=1) replaces exactly the masked window bytes with the same bytes of `xfr_wdata_i`. Bit 0 of slot 25 selects accumulate mode (1) or multiply-only mode (0). Bits 31:2 of slot 25 always read zero.
- R6: When the mode after a legal write that starts at register 25 is accumulate, the block adds the product of the current operands to the accumulator. The sum goes to both the product words and the accumulator, and it overrides any product bytes written by the same transfer.
- R7: In accumulate mode, the product words change only through such a write or through direct byte writes. Operand changes and read transfers leave them as they are.
- R8: When an accumulate step wraps past 2^64, bit 1 of slot 25 (carry) becomes 1. It stays 1 across later writes that carry a 0 in that bit.
- R9: A legal write covering byte 0 of slot 25 with bit 1 set clears the carry and zeroes the accumulator. This is applied after that same write's accumulate step, so the product words keep the new sum.
- R10: Any cycle in multiply-only mode zeroes the accumulator, so the first accumulate after re-entering accumulate mode starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a_i | input | 32 | First multiplier operand (CPU register 28) |
| op_b_i | input | 32 | Second multiplier operand (CPU register 29) |
| xfr_valid_i | input | 1 | Transfer request this cycle |
| xfr_dir_i | input | 1 | 1 = write CPU bytes into the block, 0 = read |
| xfr_reg_i | input | 5 | Start register index |
| xfr_lane_i | input | 2 | Start byte lane within the start register |
| xfr_len_i | input | 7 | Transfer length in bytes |
| xfr_wdata_i | input | 96 | Image of CPU registers 25..27, byte 0 = register 25 bits 7:0 |
| xfr_rdata_o | output | 96 | Image of the block's window, same byte order |
| xfr_mask_o | output | 12 | Window bytes touched by the current legal transfer |
| xfr_err_o | output | 1 | Current valid transfer is out of range |

## Verification
A single write that starts at register 25 in accumulate mode can do three things at once: accumulate, set the carry through a wrap, and clear the carry through the write-1 bit. The bench first drives two full-scale accumulate steps so the carry becomes visible. It then issues one write that carries bit 1 set together with new operands. The product words must show the new sum, while the carry must read clear. A following accumulate from small operands must equal their bare product, which proves the accumulator was zeroed in that same cycle and not before the add.

// File: rtl/mac_cop_pkg.sv
package mac_cop_pkg;
    // bit positions inside the control word (window slot 0)
    localparam int MODE_BIT  = 0;
    localparam int CARRY_BIT = 1;

    typedef enum logic {
        XFR_READ  = 1'b0,
        XFR_WRITE = 1'b1
    } xfr_dir_e;
endpackage

// File: rtl/mac_xfer_check.sv
module mac_xfer_check #(
    parameter int REGW   = 5,
    parameter int LANEW  = 2,
    parameter int LENW   = 7,
    parameter int FIRST  = 25,
    parameter int NSLOT  = 3
) (
    input  logic                      valid_i,
    input  logic [REGW-1:0]           reg_i,
    input  logic [LANEW-1:0]          lane_i,
    input  logic [LENW-1:0]           len_i,
    output logic                      legal_o,
    output logic                      err_o,
    output logic                      at_first_o,
    output logic [NSLOT*(1<<LANEW)-1:0] mask_o
);
    localparam int BPW    = 1 << LANEW;
    localparam int NBYTES = NSLOT * BPW;
    localparam int BASE   = FIRST * BPW;
    localparam int LIMIT  = (FIRST + NSLOT) * BPW;
    localparam int AW     = REGW + LANEW;
    localparam int SW     = ((AW > LENW) ? AW : LENW) + 1;

    logic [SW-1:0] pos;
    logic [SW-1:0] end_pos;

    assign pos        = SW'({reg_i, lane_i});
    assign end_pos    = pos + SW'(len_i);
    assign legal_o    = (reg_i >= REGW'(FIRST)) && (end_pos <= SW'(LIMIT));
    assign err_o      = valid_i && !legal_o;
    assign at_first_o = valid_i && legal_o && (reg_i == REGW'(FIRST));

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign mask_o[k] = valid_i && legal_o
                         && (pos <= SW'(BASE + k)) && (SW'(BASE + k) < end_pos);
    end
endmodule

// File: rtl/mac_arith.sv
module mac_arith #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic [2*DW-1:0] acc_i,
    output logic [2*DW-1:0] prod_o,
    output logic [2*DW-1:0] sum_o,
    output logic            wrap_o
);
    localparam int PW = 2 * DW;

    assign prod_o          = PW'(a_i) * PW'(b_i);
    assign {wrap_o, sum_o} = {1'b0, acc_i} + {1'b0, prod_o};
endmodule

// File: rtl/mac_coproc.sv
module mac_coproc
    import mac_cop_pkg::*;
#(
    parameter int DW         = 32,
    parameter int REGW       = 5,
    parameter int LENW       = 7,
    parameter int FIRST_SLOT = 25
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         op_a_i,
    input  logic [DW-1:0]         op_b_i,
    input  logic                  xfr_valid_i,
    input  logic                  xfr_dir_i,
    input  logic [REGW-1:0]       xfr_reg_i,
    input  logic [$clog2(DW/8)-1:0] xfr_lane_i,
    input  logic [LENW-1:0]       xfr_len_i,
    input  logic [3*DW-1:0]       xfr_wdata_i,
    output logic [3*DW-1:0]       xfr_rdata_o,
    output logic [3*(DW/8)-1:0]   xfr_mask_o,
    output logic                  xfr_err_o
);
    localparam int NSLOT  = 3;           // control word + product pair
    localparam int BPW    = DW / 8;
    localparam int LANEW  = $clog2(BPW);
    localparam int NBYTES = NSLOT * BPW;
    localparam int WINW   = NSLOT * DW;
    localparam int PW     = 2 * DW;

    typedef struct packed {
        logic          acc_mode;
        logic          carry;
        logic [PW-1:0] prod;
        logic [PW-1:0] acc;
    } state_t;

    state_t state_d, state_q;

    logic              legal, at_first;
    logic [PW-1:0]     mul, sum;
    logic              wrap;
    logic [WINW-1:0]   win_q, merged;
    logic              wr_hit, acc_hit, clr_req;

    mac_xfer_check #(
        .REGW(REGW), .LANEW(LANEW), .LENW(LENW), .FIRST(FIRST_SLOT), .NSLOT(NSLOT)
    ) u_chk (
        .valid_i    (xfr_valid_i),
        .reg_i      (xfr_reg_i),
        .lane_i     (xfr_lane_i),
        .len_i      (xfr_len_i),
        .legal_o    (legal),
        .err_o      (xfr_err_o),
        .at_first_o (at_first),
        .mask_o     (xfr_mask_o)
    );

    mac_arith #(.DW(DW)) u_arith (
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .acc_i  (state_q.acc),
        .prod_o (mul),
        .sum_o  (sum),
        .wrap_o (wrap)
    );

    // window image: slot 0 control word, slots 1..2 product low/high
    assign win_q       = {state_q.prod, {(DW-2){1'b0}}, state_q.carry, state_q.acc_mode};
    assign xfr_rdata_o = win_q;

    assign wr_hit  = xfr_valid_i && (xfr_dir_i == XFR_WRITE) && legal;
    assign acc_hit = wr_hit && at_first;
    assign clr_req = wr_hit && xfr_mask_o[0] && xfr_wdata_i[CARRY_BIT];

    for (genvar k = 0; k < NBYTES; k++) begin : g_merge
        assign merged[k*8 +: 8] = (wr_hit && xfr_mask_o[k]) ? xfr_wdata_i[k*8 +: 8]
                                                             : win_q[k*8 +: 8];
    end

    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^merged[DW-1:0];

    always_comb begin
        state_d          = state_q;
        state_d.acc_mode = merged[MODE_BIT];
        if (!merged[MODE_BIT]) begin
            state_d.prod = mul;
            state_d.acc  = '0;
        end else if (acc_hit) begin
            state_d.prod  = sum;
            state_d.acc   = sum;
            state_d.carry = state_q.carry | wrap;
        end else begin
            state_d.prod = merged[WINW-1:DW];
        end
        if (clr_req) begin
            state_d.carry = 1'b0;
            state_d.acc   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // ---------------- assertions ----------------
    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    // R2: free-running product follows the operands one cycle later
    p_mul_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !state_q.acc_mode)
        |-> state_q.prod == PW'($past(op_a_i)) * PW'($past(op_b_i)));

    // R10: accumulator empty while multiply-only
    p_acc_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.acc_mode |-> state_q.acc == '0);

    // R3: rejected transfer touches no byte and changes no control state
    p_err_no_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfr_err_o |-> xfr_mask_o == '0);
    p_err_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfr_err_o |=> ($stable(state_q.acc_mode) && $stable(state_q.carry)));

    // R4: mask population equals the requested length
    p_mask_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfr_valid_i && !xfr_err_o) |-> $countones(xfr_mask_o) == int'(xfr_len_i));

    // R7: accumulate mode without any write holds the product
    p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.acc_mode && !(xfr_valid_i && xfr_dir_i)) |=> $stable(state_q.prod));

    // R8: carry is sticky unless explicitly cleared
    p_carry_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.carry && !(xfr_valid_i && xfr_dir_i && !xfr_err_o
                            && xfr_mask_o[0] && xfr_wdata_i[CARRY_BIT]))
        |=> state_q.carry);

    // R9: write-one clears carry and empties accumulator
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfr_valid_i && xfr_dir_i && !xfr_err_o && xfr_mask_o[0] && xfr_wdata_i[CARRY_BIT])
        |=> (!state_q.carry && state_q.acc == '0));
endmodule

// File: tb/sim_mac_coproc.sv
module sim_mac_coproc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        xv = 1'b0, xd = 1'b0;
    logic [4:0]  xr = '0;
    logic [1:0]  xl = '0;
    logic [6:0]  xn = '0;
    logic [95:0] xw = '0;
    logic [95:0] rdata;
    logic [11:0] mask;
    logic        err;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mac_coproc u0 (
        .clk(clk), .rst_n(rst_n), .op_a_i(op_a), .op_b_i(op_b),
        .xfr_valid_i(xv), .xfr_dir_i(xd), .xfr_reg_i(xr), .xfr_lane_i(xl),
        .xfr_len_i(xn), .xfr_wdata_i(xw), .xfr_rdata_o(rdata),
        .xfr_mask_o(mask), .xfr_err_o(err)
    );

    localparam logic [63:0] MUL_VEC [6] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'h0000_0001, 32'h0000_0001},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'hFFFF_FFFF, 32'h0000_0002},
        {32'h1234_5678, 32'h0000_0010},
        {32'h8000_0000, 32'h8000_0000}
    };

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] r, input logic [1:0] l, input logic [6:0] n,
                      input logic [95:0] d);
        @(negedge clk);
        xv = 1'b1; xd = 1'b1; xr = r; xl = l; xn = n; xw = d;
        @(negedge clk);
        xv = 1'b0; xd = 1'b0;
    endtask

    task automatic probe(input string tag, input logic dir, input logic [4:0] r,
                         input logic [1:0] l, input logic [6:0] n,
                         input logic exp_err, input logic [11:0] exp_mask);
        @(negedge clk);
        xv = 1'b1; xd = dir; xr = r; xl = l; xn = n; xw = '0;
        #1;
        chk({tag, " err"}, 96'(err), 96'(exp_err));
        chk({tag, " mask"}, 96'(mask), 96'(exp_mask));
        xv = 1'b0; xd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        op_a = 32'h55; op_b = 32'h77;
        repeat (3) @(negedge clk);
        chk("R1 window in reset", rdata, '0);
        op_a = '0; op_b = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 window after reset", rdata, '0);

        // R2: table of operand pairs in multiply-only mode
        foreach (MUL_VEC[i]) begin
            @(negedge clk);
            op_a = MUL_VEC[i][63:32];
            op_b = MUL_VEC[i][31:0];
            @(negedge clk);
            chk("R2 multiply-only product",
                rdata, {64'(MUL_VEC[i][63:32]) * 64'(MUL_VEC[i][31:0]), 32'h0});
        end

        // R3/R4: legality and byte masks (reads, combinational)
        probe("R4 reg26 lane2 len3", 1'b0, 5'd26, 2'd2, 7'd3, 1'b0, 12'h1C0);
        probe("R4 whole window", 1'b0, 5'd25, 2'd0, 7'd12, 1'b0, 12'hFFF);
        probe("R4 last byte", 1'b0, 5'd27, 2'd3, 7'd1, 1'b0, 12'h800);
        probe("R3 past end", 1'b0, 5'd27, 2'd3, 7'd2, 1'b1, 12'h000);
        probe("R3 below window", 1'b0, 5'd24, 2'd0, 7'd4, 1'b1, 12'h000);
        probe("R3 lane overflow", 1'b0, 5'd25, 2'd1, 7'd12, 1'b1, 12'h000);

        // R5: enter accumulate mode with zero operands, then byte-merge product
        op_a = '0; op_b = '0;
        wr(5'd25, 2'd0, 7'd1, 96'h1);
        chk("R5 enter accumulate", rdata, {64'h0, 32'h1});
        wr(5'd26, 2'd1, 7'd2, 96'hFFFFFFFF_FFCDABFF_FFFFFFFF);
        chk("R5 byte merge", rdata, {32'h0, 32'h00CDAB00, 32'h1});

        // R7: operand change and a read leave the product alone
        op_a = 32'd7; op_b = 32'd9;
        probe("R7 read mask", 1'b0, 5'd25, 2'd0, 7'd12, 1'b0, 12'hFFF);
        repeat (2) @(negedge clk);
        chk("R7 hold in accumulate", rdata, {32'h0, 32'h00CDAB00, 32'h1});

        // R6: accumulate steps
        op_a = 32'd3; op_b = 32'd5;
        wr(5'd25, 2'd0, 7'd1, 96'h1);
        chk("R6 first accumulate", rdata, {64'd15, 32'h1});
        op_a = 32'd10; op_b = 32'd10;
        wr(5'd25, 2'd0, 7'd1, 96'h1);
        chk("R6 second accumulate", rdata, {64'd115, 32'h1});

        // R8: wrap sets carry, carry persists
        op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF;
        wr(5'd25, 2'd0, 7'd1, 96'h1);
        chk("R8 no wrap yet", rdata, {64'hFFFFFFFE_00000074, 32'h1});
        wr(5'd25, 2'd0, 7'd1, 96'h1);
        chk("R8 wrap sets carry", rdata, {64'hFFFFFFFC_00000075, 32'h3});
        op_a = '0; op_b = '0;
        wr(5'd25, 2'd0, 7'd1, 96'h1);
        chk("R8 carry sticky", rdata, {64'hFFFFFFFC_00000075, 32'h3});

        // R9: clear in same write as an accumulate
        op_a = 32'd2; op_b = 32'd3;
        wr(5'd25, 2'd0, 7'd1, 96'h3);
        chk("R9 sum kept carry cleared", rdata, {64'hFFFFFFFC_0000007B, 32'h1});
        op_a = 32'd1; op_b = 32'd7;
        wr(5'd25, 2'd0, 7'd1, 96'h1);
        chk("R9 accumulator emptied", rdata, {64'd7, 32'h1});

        // R10: back to multiply-only and re-enter accumulate
        op_a = 32'd4; op_b = 32'd4;
        wr(5'd25, 2'd0, 7'd1, 96'h0);
        chk("R10 multiply-only again", rdata, {64'd16, 32'h0});
        op_a = 32'd2; op_b = 32'd2;
        wr(5'd25, 2'd0, 7'd1, 96'h1);
        chk("R10 accumulate restarts from zero", rdata, {64'd4, 32'h1});
        wr(5'd25, 2'd0, 7'd1, 96'h1);
        chk("R10 second step", rdata, {64'd8, 32'h1});

        // R3: illegal writes have no effect
        wr(5'd24, 2'd0, 7'd8, 96'h0);
        chk("R3 illegal write below window", rdata, {64'd8, 32'h1});
        wr(5'd25, 2'd1, 7'd12, 96'h0);
        chk("R3 illegal write past end", rdata, {64'd8, 32'h1});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule